// File: doc/BRIEF.md
# Dual-Timing Multiplexed Parallel Host Port

This block is a slave port that gives a host processor access to a bank of 8-bit registers over a multiplexed 8-bit address/data bus. A falling edge on the address-latch input captures the address byte. The upper nibble of that byte must equal a 4-bit strapped device address. The lower bits pick one register. A later strobe reads or writes that register.

A timing-select input chooses between two strobe conventions. In split-strobe timing, separate active-low read and write strobes mark the access. In single-strobe timing, an active-high data strobe marks the access and a direction line gives read (high) or write (low). Only single-strobe timing produces an active-low acknowledge pulse. In split-strobe timing that output stays high.

All bus inputs except the strap pass through one register stage in the block clock domain, and every decision is taken on the registered copies. The data bus is modelled as separate input, output and output-enable pins, which the pad ring combines into a tri-state driver.

Top module: `hp_mux_port`

## Requirements
- R1: After reset every register reads 0x00, `ad_oe_o` is low and `ack_n_o` is high.
- R2: A falling edge on `ale_i` latches `ad_i`. Bits [3:0] of the latched byte select one of 16 registers. The latched address stays in force until the next falling edge, so successive accesses reuse it.
- R3: With `timing_sel_i` = 0 and `cs_n_i` low, `stb0_i` low with `stb1_i` high is a read, and `stb1_i` low with `stb0_i` high is a write of `ad_i`.
- R4: With `timing_sel_i` = 1 and `cs_n_i` low, `stb0_i` high is an access. `stb1_i` = 1 makes it a read and `stb1_i` = 0 makes it a write.
- R5: An access whose latched bits [7:4] differ from `dev_addr_i` writes nothing, does not drive the bus and gives no acknowledge.
- R6: `ad_oe_o` is high only during a matching read. While it is high, `ad_o` carries the selected register.
- R7: With `timing_sel_i` = 1, each matching access drives `ack_n_o` low for exactly two clock cycles, starting two clock edges after the strobe reaches the pins.
- R8: With `timing_sel_i` = 0, `ack_n_o` stays high for every access.
- R9: With `timing_sel_i` = 0, both strobes low together is ignored: no write and no bus drive.
- R10: A strobe while `cs_n_i` is high is ignored.
- R11: If an access starts in the same cycle as an `ale_i` falling edge, the access uses the address latched before that edge.
- R12: A strobe held over several cycles commits exactly one write, which holds the data present when the strobe began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_sel_i | input | 1 | 0 = split strobes, 1 = data strobe with direction |
| dev_addr_i | input | 4 | Strapped device address |
| cs_n_i | input | 1 | Chip select, active low |
| ale_i | input | 1 | Address latch; the falling edge captures `ad_i` |
| stb0_i | input | 1 | Read strobe (low) or data strobe (high) |
| stb1_i | input | 1 | Write strobe (low) or direction (1 = read) |
| ad_i | input | 8 | Bus value seen at the pads |
| ad_o | output | 8 | Read data toward the pads |
| ad_oe_o | output | 1 | Pad output enable |
| ack_n_o | output | 1 | Acknowledge, active low |

## Verification
An address latch and the start of an access can land in the same registered cycle. The bench provokes this by dropping `ale_i` on the same clock edge that asserts a write strobe, while the bus still carries the new address byte. It then judges the result by reading back both registers: the previously latched register must hold that byte, and the newly addressed one must be untouched. A held strobe with data changing mid-access is also driven, to confirm that the write commits only once.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic {
    TIM_SPLIT  = 1'b0,
    TIM_STROBE = 1'b1
  } timing_e;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RSTV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RSTV;
    else        q <= d;
  end
endmodule

// File: rtl/hp_decode.sv
module hp_decode
  import hp_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned CAW = 4,
  localparam int unsigned IDXW = DW - CAW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  timing_e         mode,
  input  logic            cs_n,
  input  logic            ale,
  input  logic            stb0,
  input  logic            stb1,
  input  logic [DW-1:0]   ad,
  input  logic [CAW-1:0]  dev_addr,
  output logic [IDXW-1:0] idx,
  output logic            wr_fire,
  output logic            rd_drive,
  output logic            ack_fire
);
  logic [DW-1:0] addr_q;
  logic ale_d, act_d;
  logic rd_req, wr_req, act, start, hit;

  always_comb begin
    if (mode == TIM_STROBE) begin
      rd_req = stb1;
      wr_req = !stb1;
      act    = !cs_n && stb0;
    end else begin
      rd_req = !stb0 && stb1;
      wr_req = !stb1 && stb0;
      act    = !cs_n && (rd_req || wr_req);
    end
  end

  assign hit      = (addr_q[DW-1 -: CAW] == dev_addr);
  assign start    = act && !act_d;
  assign idx      = addr_q[IDXW-1:0];
  assign wr_fire  = start && wr_req && hit;
  assign rd_drive = act && rd_req && hit;
  assign ack_fire = start && hit && (mode == TIM_STROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ale_d  <= 1'b0;
      act_d  <= 1'b0;
    end else begin
      ale_d <= ale;
      act_d <= act;
      if (ale_d && !ale) addr_q <= ad;
    end
  end

  // one commit per strobe (R12)
  assert_one_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
endmodule

// File: rtl/hp_regbank.sv
module hp_regbank #(
  parameter int unsigned DW   = 8,
  parameter int unsigned IDXW = 4,
  localparam int unsigned NREG = 1 << IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : gen_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       q <= '0;
      else if (we && idx == IDXW'(g))   q <= wdata;
    end
    assign bank[g] = q;
  end

  assign rdata = bank[idx];
endmodule

// File: rtl/hp_ack.sv
module hp_ack #(
  parameter int unsigned ACK_CYC = 2,
  localparam int unsigned CW = $clog2(ACK_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic ack_n
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (fire)       cnt <= CW'(ACK_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign ack_n = (cnt == '0);

  // a pulse only follows a matching access in strobe timing (R7)
  assert_ack_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(fire));

  if (ACK_CYC > 1) begin : gen_min
    assert_ack_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_n) |=> !ack_n);
  end
endmodule

// File: rtl/hp_mux_port.sv
module hp_mux_port
  import hp_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned CAW     = 4,
  parameter int unsigned ACK_CYC = 2,
  localparam int unsigned IDXW   = DW - CAW,
  localparam int unsigned SW     = DW + 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           timing_sel_i,
  input  logic [CAW-1:0] dev_addr_i,
  input  logic           cs_n_i,
  input  logic           ale_i,
  input  logic           stb0_i,
  input  logic           stb1_i,
  input  logic [DW-1:0]  ad_i,
  output logic [DW-1:0]  ad_o,
  output logic           ad_oe_o,
  output logic           ack_n_o
);
  localparam logic [SW-1:0] SYNC_RST = {5'b01011, {DW{1'b0}}};

  logic [SW-1:0]   s_bus;
  logic [DW-1:0]   s_ad;
  logic            s_tim, s_cs_n, s_ale, s_stb0, s_stb1;
  logic [IDXW-1:0] idx;
  logic            wr_fire, rd_drive, ack_fire;

  hp_sync #(.W(SW), .RSTV(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({timing_sel_i, cs_n_i, ale_i, stb0_i, stb1_i, ad_i}),
    .q(s_bus)
  );

  assign {s_tim, s_cs_n, s_ale, s_stb0, s_stb1, s_ad} = s_bus;

  hp_decode #(.DW(DW), .CAW(CAW)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .mode(timing_e'(s_tim)), .cs_n(s_cs_n), .ale(s_ale),
    .stb0(s_stb0), .stb1(s_stb1), .ad(s_ad), .dev_addr(dev_addr_i),
    .idx(idx), .wr_fire(wr_fire), .rd_drive(rd_drive), .ack_fire(ack_fire)
  );

  hp_regbank #(.DW(DW), .IDXW(IDXW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .we(wr_fire), .idx(idx), .wdata(s_ad), .rdata(ad_o)
  );

  hp_ack #(.ACK_CYC(ACK_CYC)) u_ack (
    .clk(clk), .rst_n(rst_n), .fire(ack_fire), .ack_n(ack_n_o)
  );

  assign ad_oe_o = rd_drive;

  // bus drive and register write never coincide (R6)
  assert_drive_not_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_o |-> !wr_fire);
endmodule

// File: tb/sim_hp_mux_port.sv
module sim_hp_mux_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, tsel, cs_n, ale, stb0, stb1;
  logic [3:0] dev;
  logic [7:0] ad_i, ad_o;
  logic       ad_oe, ack_n;

  hp_mux_port u0 (
    .clk(clk), .rst_n(rst_n), .timing_sel_i(tsel), .dev_addr_i(dev),
    .cs_n_i(cs_n), .ale_i(ale), .stb0_i(stb0), .stb1_i(stb1),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe), .ack_n_o(ack_n)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int obs_ack;
  bit obs_oe;
  logic [7:0] obs_rd;

  // {timing, address byte, data}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'hA3, 8'h5C}, {1'b1, 8'hA7, 8'h3E}, {1'b0, 8'hAF, 8'hFF},
    {1'b1, 8'hA0, 8'h81}, {1'b1, 8'hA3, 8'hC4}, {1'b0, 8'hA7, 8'h19}
  };

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1;
    stb0 = (tsel == 1'b0);
    stb1 = 1'b1;
  endtask

  task automatic latch(logic [7:0] a);
    @(negedge clk); ad_i = a; ale = 1'b1;
    @(negedge clk); ale = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic acc(bit wr, logic [7:0] d, bit csn);
    @(negedge clk);
    ad_i = d; cs_n = csn;
    if (tsel == 1'b0) begin stb0 = wr; stb1 = !wr; end
    else begin stb0 = 1'b1; stb1 = !wr; end
    obs_ack = 0; obs_oe = 1'b0; obs_rd = 8'h00;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (!ack_n) obs_ack++;
      if (ad_oe) obs_oe = 1'b1;
      if (k == 2) obs_rd = ad_o;
    end
    idle();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (!ack_n) obs_ack++;
      if (ad_oe) obs_oe = 1'b1;
    end
  endtask

  task automatic rd_expect(string rq, logic [7:0] a, logic [7:0] exp);
    latch(a);
    acc(1'b0, 8'h00, 1'b0);
    chk(rq, obs_rd, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tsel = 1'b0; dev = 4'hA; ale = 1'b0; ad_i = 8'h00;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe after reset", ad_oe, 0);
    chk("R1 ack after reset", ack_n, 1);
    rd_expect("R1 reset register value", 8'hA0, 8'h00);

    // vector walk: write then read back, counting acknowledge cycles
    for (int i = 0; i < 6; i++) begin
      tsel = VEC[i][16]; idle();
      latch(VEC[i][15:8]);
      acc(1'b1, VEC[i][7:0], 1'b0);
      chk(tsel ? "R7 write ack cycles" : "R8 write ack absent", obs_ack, tsel ? 2 : 0);
      chk("R6 no drive on write", obs_oe, 0);
      latch(VEC[i][15:8]);
      acc(1'b0, 8'h00, 1'b0);
      chk(tsel ? "R4 strobe-timing readback" : "R3 split-timing readback", obs_rd, VEC[i][7:0]);
      chk("R6 drive on matching read", obs_oe, 1);
      chk(tsel ? "R7 read ack cycles" : "R8 read ack absent", obs_ack, tsel ? 2 : 0);
    end

    // register selection across timings
    tsel = 1'b0; idle();
    rd_expect("R2 reg 3", 8'hA3, 8'hC4);
    rd_expect("R2 reg 7", 8'hA7, 8'h19);
    tsel = 1'b1; idle();
    rd_expect("R2 reg 15", 8'hAF, 8'hFF);
    rd_expect("R2 reg 0", 8'hA0, 8'h81);

    // device address mismatch
    latch(8'h53);
    acc(1'b1, 8'h77, 1'b0);
    chk("R5 no ack on mismatch", obs_ack, 0);
    latch(8'h5F);
    acc(1'b0, 8'h00, 1'b0);
    chk("R5 no drive on mismatch", obs_oe, 0);
    tsel = 1'b0; idle();
    rd_expect("R5 reg 3 unchanged", 8'hA3, 8'hC4);

    // chip select high
    latch(8'hA7);
    acc(1'b1, 8'h66, 1'b1);
    chk("R10 no drive, cs high", obs_oe, 0);
    rd_expect("R10 reg 7 unchanged", 8'hA7, 8'h19);

    // both split strobes low
    latch(8'hA0);
    @(negedge clk); ad_i = 8'h55; cs_n = 1'b0; stb0 = 1'b0; stb1 = 1'b0;
    obs_oe = 1'b0;
    for (int k = 0; k < 4; k++) begin @(negedge clk); if (ad_oe) obs_oe = 1'b1; end
    idle(); repeat (2) @(negedge clk);
    chk("R9 no drive, both strobes", obs_oe, 0);
    rd_expect("R9 reg 0 unchanged", 8'hA0, 8'h81);

    // long strobe with data changing mid-access
    tsel = 1'b1; idle();
    latch(8'hAF);
    @(negedge clk); ad_i = 8'h12; cs_n = 1'b0; stb0 = 1'b1; stb1 = 1'b0;
    obs_ack = 0;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (k == 2) ad_i = 8'h34;
      if (!ack_n) obs_ack++;
    end
    idle(); repeat (2) @(negedge clk);
    chk("R12 single ack on long strobe", obs_ack, 2);
    rd_expect("R12 first data kept", 8'hAF, 8'h12);

    // address latch and write start in the same cycle
    tsel = 1'b0; idle();
    latch(8'hA1);
    @(negedge clk); ad_i = 8'hA2; ale = 1'b1;
    @(negedge clk); ale = 1'b0; cs_n = 1'b0; stb0 = 1'b1; stb1 = 1'b0;
    repeat (4) @(negedge clk);
    idle(); repeat (2) @(negedge clk);
    acc(1'b0, 8'h00, 1'b0);
    chk("R11 new address reg 2 untouched", obs_rd, 8'h00);
    rd_expect("R11 old address reg 1 written", 8'hA1, 8'hA2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule